// File: doc/BRIEF.md
# SPI FIFO Status and Request Logic

This block sits beside the transmit and receive FIFOs of an SPI controller and turns their occupancy into flags, requests and an interrupt. It samples the word count of each FIFO, a pulse that marks a word being written into the receive FIFO, and a busy indication from the serial engine. From these it builds an eight-bit status word. Six of its bits follow the FIFO levels. Two bits are sticky events that software clears by writing ones.

The same status word drives an interrupt line through a per-bit enable mask. It also drives three DMA request lines, each with its own enable: a transmit refill request, a receive threshold request, and a receive tail request. The tail request asks for the last few words left in the receive FIFO once the transfer has gone idle and fewer words remain than one receive DMA burst. A small two-state machine tracks whether a transfer is in progress. It produces the transfer-complete event and gates the tail request. The FIFO storage and the shifter live outside this block.

All outputs are registered or built from registered state. A change at the inputs therefore shows at the outputs one clock edge later.

The transfer tracker has two states. XF_QUIET is the reset state. XF_MOVING is entered by the transition "start", taken from XF_QUIET when the engine is busy or the transmit count is nonzero. The transition "finish" returns to XF_QUIET from XF_MOVING once the transmit count is zero and the engine is not busy, and it raises the completion event.

Top module: `spiq_status`

## Requirements
- R1: While `rst_n` is low, `status`, `irq`, `dma_req`, `tx_level` and `rx_level` are all zero.
- R2: One edge after the inputs are applied, the level bits of `status` are set as follows. Bit 0 is set when `tx_count` is 0. Bit 2 is set when `tx_count` equals DEPTH. Bit 3 is set when `rx_count` is nonzero. Bit 5 is set when `rx_count` equals DEPTH.
- R3: Status bit 1, the transmit data request, is set one edge after `tx_count <= tx_thresh` holds, and is clear otherwise.
- R4: Status bit 4, the receive data request, is set one edge after `rx_count > rx_thresh` holds, and is clear otherwise.
- R5: Status bit 6, receive overflow, is set one edge after `rx_push` is high while `rx_count` equals DEPTH. It stays set after the FIFO drains, until it is cleared.
- R6: When `clr_we` is high, a 1 in `clr_mask` bit 6 or bit 7 clears that status bit at the next edge, and a 0 leaves it unchanged. A set event in the same cycle takes priority over the clear.
- R7: Clear writes do not affect bits 0 to 5, which keep following the FIFO counts.
- R8: Status bit 7, transfer completed, is set on the edge where the tracker takes "finish", meaning the transmit count is 0 and the engine is not busy after a transfer had started. It is not set by the idle condition that holds after reset.
- R9: `irq` is high exactly when some bit of `status` is set and its bit in `int_en` is 1.
- R10: `dma_req[0]` equals `dma_en[0]` AND status bit 1. `dma_req[1]` equals `dma_en[1]` AND status bit 4.
- R11: `dma_req[2]` is high one edge after all of the following hold: `dma_en[2]` is high, `tx_count` is 0, the engine is not busy, and `rx_count` is nonzero and below `rx_dma_len`.
- R12: `tx_level` and `rx_level` report `tx_count` and `rx_count` delayed by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_count | input | CW | Words held in the transmit FIFO |
| rx_count | input | CW | Words held in the receive FIFO |
| rx_push | input | 1 | A received word is being written this cycle |
| engine_busy | input | 1 | Serial engine is shifting |
| tx_thresh | input | CW | Transmit request threshold |
| rx_thresh | input | CW | Receive request threshold |
| rx_dma_len | input | CW | Receive DMA burst length in words |
| int_en | input | 8 | Interrupt enable per status bit |
| dma_en | input | 3 | Enables for transmit, receive-threshold and receive-tail requests |
| clr_we | input | 1 | Status clear write strobe |
| clr_mask | input | 8 | Bits to clear (write one to clear) |
| status | output | 8 | Status flags |
| irq | output | 1 | Interrupt line |
| dma_req | output | 3 | DMA request lines |
| tx_level | output | CW | Reported transmit word count |
| rx_level | output | CW | Reported receive word count |

## Verification
A stuck or mis-stepped tracker state shows up at the ports within one edge. Either bit 7 fails to rise on the idle edge after a transfer, or it rises with no transfer, or `dma_req[2]` appears while words are still being sent. A sticky register that loses its value shows up as status bit 6 or bit 7 dropping on the edge after a cycle with no clear write. A level register that wrongly honours clears shows up on the edge after the write. The bench steps through transfer sequences, samples every output one edge after each input change, and includes same-cycle set-and-clear collisions.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
    typedef enum logic [0:0] {
        XF_QUIET  = 1'b0,
        XF_MOVING = 1'b1
    } xfer_state_e;

    localparam int ST_TX_EMPTY = 0;
    localparam int ST_TX_REQ   = 1;
    localparam int ST_TX_FULL  = 2;
    localparam int ST_RX_READY = 3;
    localparam int ST_RX_REQ   = 4;
    localparam int ST_RX_FULL  = 5;
    localparam int ST_RX_OVF   = 6;
    localparam int ST_DONE     = 7;
    localparam int ST_W        = 8;

    localparam int DQ_TX   = 0;
    localparam int DQ_RX   = 1;
    localparam int DQ_TAIL = 2;
    localparam int DQ_W    = 3;

    localparam int N_STICKY = 2;
endpackage

// File: rtl/spiq_level_flags.sv
module spiq_level_flags #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_thresh,
    input  logic [CW-1:0] rx_thresh,
    input  logic [CW-1:0] rx_dma_len,
    input  logic          rx_push,
    output logic          tx_empty,
    output logic          tx_req,
    output logic          tx_full,
    output logic          rx_ready,
    output logic          rx_req,
    output logic          rx_full,
    output logic          ovf_evt,
    output logic          tail_cand
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    always_comb begin
        tx_empty  = (tx_count == '0);
        tx_req    = (tx_count <= tx_thresh);
        tx_full   = (tx_count == FULL_CNT);
        rx_ready  = (rx_count != '0);
        rx_req    = (rx_count > rx_thresh);
        rx_full   = (rx_count == FULL_CNT);
        ovf_evt   = rx_push && (rx_count == FULL_CNT);
        tail_cand = (rx_count != '0) && (rx_count < rx_dma_len);
    end
endmodule

// File: rtl/spiq_xfer_fsm.sv
module spiq_xfer_fsm
    import spiq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic engine_busy,
    output logic done_evt,
    output logic quiet_next
);
    xfer_state_e state_q, state_d;
    logic        idle_now;

    assign idle_now = tx_empty && !engine_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XF_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        done_evt = 1'b0;
        unique case (state_q)
            XF_QUIET: begin
                if (!idle_now) state_d = XF_MOVING;       // start
            end
            XF_MOVING: begin
                if (idle_now) begin                       // finish
                    state_d  = XF_QUIET;
                    done_evt = 1'b1;
                end
            end
            default: state_d = XF_QUIET;
        endcase
        quiet_next = (state_d == XF_QUIET);
    end
endmodule

// File: rtl/spiq_sticky_bit.sv
module spiq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end
endmodule

// File: rtl/spiq_status.sv
module spiq_status
    import spiq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_push,
    input  logic          engine_busy,
    input  logic [CW-1:0] tx_thresh,
    input  logic [CW-1:0] rx_thresh,
    input  logic [CW-1:0] rx_dma_len,
    input  logic [7:0]    int_en,
    input  logic [2:0]    dma_en,
    input  logic          clr_we,
    input  logic [7:0]    clr_mask,
    output logic [7:0]    status,
    output logic          irq,
    output logic [2:0]    dma_req,
    output logic [CW-1:0] tx_level,
    output logic [CW-1:0] rx_level
);
    localparam int N_LEVEL = ST_W - N_STICKY;
    localparam int STICKY_POS [N_STICKY] = '{ST_RX_OVF, ST_DONE};

    logic tx_empty, tx_req, tx_full, rx_ready, rx_req, rx_full;
    logic ovf_evt, tail_cand, done_evt, quiet_next;

    logic [N_LEVEL-1:0]  level_d, level_q;
    logic [N_STICKY-1:0] sticky_set, sticky_q;
    logic                tail_q;
    logic [CW-1:0]       tx_lvl_q, rx_lvl_q;

    spiq_level_flags #(.DEPTH(DEPTH), .CW(CW)) u_levels (
        .tx_count  (tx_count),
        .rx_count  (rx_count),
        .tx_thresh (tx_thresh),
        .rx_thresh (rx_thresh),
        .rx_dma_len(rx_dma_len),
        .rx_push   (rx_push),
        .tx_empty  (tx_empty),
        .tx_req    (tx_req),
        .tx_full   (tx_full),
        .rx_ready  (rx_ready),
        .rx_req    (rx_req),
        .rx_full   (rx_full),
        .ovf_evt   (ovf_evt),
        .tail_cand (tail_cand)
    );

    spiq_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_empty   (tx_empty),
        .engine_busy(engine_busy),
        .done_evt   (done_evt),
        .quiet_next (quiet_next)
    );

    assign level_d    = {rx_full, rx_req, rx_ready, tx_full, tx_req, tx_empty};
    assign sticky_set = {done_evt, ovf_evt};

    generate
        for (genvar s = 0; s < N_STICKY; s++) begin : g_sticky
            spiq_sticky_bit u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_evt(sticky_set[s]),
                .clr_req(clr_we && clr_mask[STICKY_POS[s]]),
                .flag   (sticky_q[s])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q  <= '0;
            tail_q   <= 1'b0;
            tx_lvl_q <= '0;
            rx_lvl_q <= '0;
        end else begin
            level_q  <= level_d;
            tail_q   <= quiet_next && tail_cand;
            tx_lvl_q <= tx_count;
            rx_lvl_q <= rx_count;
        end
    end

    always_comb begin
        status            = '0;
        status[N_LEVEL-1:0] = level_q;
        for (int s = 0; s < N_STICKY; s++) status[STICKY_POS[s]] = sticky_q[s];
        irq               = |(status & int_en);
        dma_req[DQ_TX]    = dma_en[DQ_TX]   && status[ST_TX_REQ];
        dma_req[DQ_RX]    = dma_en[DQ_RX]   && status[ST_RX_REQ];
        dma_req[DQ_TAIL]  = dma_en[DQ_TAIL] && tail_q;
    end

    assign tx_level = tx_lvl_q;
    assign rx_level = rx_lvl_q;
endmodule

// File: rtl/spiq_status_chk.sv
module spiq_status_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          rx_push,
    input logic          engine_busy,
    input logic [CW-1:0] tx_thresh,
    input logic [CW-1:0] rx_thresh,
    input logic          clr_we,
    input logic [7:0]    clr_mask,
    input logic [7:0]    status,
    input logic [CW-1:0] tx_level
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    AST_TX_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= tx_thresh) |=> status[1]); // R3
    AST_RX_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count > rx_thresh) |=> status[4]); // R4
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_count == FULL_CNT) |=> status[6]); // R5
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !(clr_we && clr_mask[6])) |=> status[6]); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[6] && !(rx_push && rx_count == FULL_CNT)) |=> !status[6]); // R6
    AST_LEVEL_IGNORES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[0] && tx_count == '0) |=> status[0]); // R7
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[7]) |-> ($past(tx_count) == '0 && !$past(engine_busy))); // R8
    AST_COUNT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tx_level == $past(tx_count))); // R12
endmodule

bind spiq_status spiq_status_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .rx_push    (rx_push),
    .engine_busy(engine_busy),
    .tx_thresh  (tx_thresh),
    .rx_thresh  (rx_thresh),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask),
    .status     (status),
    .tx_level   (tx_level)
);

// File: tb/spiq_status_bench.sv
`timescale 1ns/1ps
module spiq_status_bench;
    localparam int DEPTH = 16;
    localparam int CW    = 5;
    localparam int NVEC  = 9;

    // {tx, rx, busy, push, clr, exp_status, exp_dma}
    localparam logic [30:0] VEC [NVEC] = '{
        {5'd0,  5'd0,  1'b0, 1'b0, 8'h00, 8'h03, 3'b001},
        {5'd10, 5'd3,  1'b1, 1'b0, 8'h00, 8'h08, 3'b000},
        {5'd16, 5'd16, 1'b1, 1'b1, 8'h00, 8'h7C, 3'b010},
        {5'd3,  5'd9,  1'b1, 1'b0, 8'h00, 8'h5A, 3'b011},
        {5'd0,  5'd2,  1'b0, 1'b0, 8'h00, 8'hCB, 3'b101},
        {5'd0,  5'd2,  1'b0, 1'b0, 8'h40, 8'h8B, 3'b101},
        {5'd0,  5'd0,  1'b0, 1'b0, 8'h0F, 8'h83, 3'b001},
        {5'd0,  5'd16, 1'b0, 1'b1, 8'hC0, 8'h7B, 3'b011},
        {5'd5,  5'd8,  1'b0, 1'b0, 8'h40, 8'h08, 3'b000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] tx_count = '0, rx_count = '0;
    logic          rx_push = 1'b0, engine_busy = 1'b0;
    logic [CW-1:0] tx_thresh = 5'd4, rx_thresh = 5'd8, rx_dma_len = 5'd4;
    logic [7:0]    int_en = 8'hFF;
    logic [2:0]    dma_en = 3'b111;
    logic          clr_we = 1'b0;
    logic [7:0]    clr_mask = '0;
    logic [7:0]    status;
    logic          irq;
    logic [2:0]    dma_req;
    logic [CW-1:0] tx_level, rx_level;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    spiq_status #(.DEPTH(DEPTH), .CW(CW)) u_spiq_status (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
        .rx_push(rx_push), .engine_busy(engine_busy), .tx_thresh(tx_thresh),
        .rx_thresh(rx_thresh), .rx_dma_len(rx_dma_len), .int_en(int_en),
        .dma_en(dma_en), .clr_we(clr_we), .clr_mask(clr_mask), .status(status),
        .irq(irq), .dma_req(dma_req), .tx_level(tx_level), .rx_level(rx_level)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] tx, input logic [4:0] rx, input logic busy,
                         input logic push, input logic [7:0] clr);
        tx_count = tx; rx_count = rx; engine_busy = busy; rx_push = push;
        clr_we = (clr != 8'h00); clr_mask = clr;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: outputs held at zero during reset with nonzero inputs
        tx_count = 5'd7; rx_count = 5'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 status", status, 0);
        check("R1 irq", irq, 0);
        check("R1 dma", dma_req, 0);
        check("R1 levels", {tx_level, rx_level}, 0);
        tx_count = '0; rx_count = '0;
        rst_n = 1'b1;

        // Table walk: R2..R8, R10, R11, R12
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][30:26], VEC[i][25:21], VEC[i][20], VEC[i][19], VEC[i][18:11]);
            check($sformatf("R2 R3 R4 R5 R6 R7 R8 status vec%0d", i), status, VEC[i][10:3]);
            check($sformatf("R10 R11 dma vec%0d", i), dma_req, VEC[i][2:0]);
            check($sformatf("R12 tx_level vec%0d", i), tx_level, VEC[i][30:26]);
            check($sformatf("R12 rx_level vec%0d", i), rx_level, VEC[i][25:21]);
            check($sformatf("R9 irq vec%0d", i), irq, (VEC[i][10:3] != 0));
        end

        // R9: masked interrupt
        int_en = 8'h40;
        drive(5'd5, 5'd8, 1'b0, 1'b0, 8'h00);
        check("R9 irq masked", irq, 0);
        drive(5'd5, 5'd16, 1'b0, 1'b1, 8'h00);
        check("R9 irq on enabled overflow", irq, 1);
        check("R5 overflow set", status[6], 1);

        // R5: overflow persists after drain
        drive(5'd5, 5'd0, 1'b0, 1'b0, 8'h00);
        check("R5 overflow sticky after drain", status[6], 1);

        // R10: DMA enables gate requests
        dma_en = 3'b000;
        drive(5'd2, 5'd12, 1'b1, 1'b0, 8'h00);
        check("R10 dma disabled", dma_req, 0);
        dma_en = 3'b010;
        drive(5'd2, 5'd12, 1'b1, 1'b0, 8'h00);
        check("R10 rx dma only", dma_req, 3'b010);

        // R3/R4 boundaries: tx equal threshold, rx equal threshold
        dma_en = 3'b111;
        drive(5'd4, 5'd8, 1'b1, 1'b0, 8'h00);
        check("R3 tx at threshold", status[1], 1);
        check("R4 rx at threshold", status[4], 0);

        // R11: tail blocked while busy, then raised when idle; boundary rx == len
        drive(5'd0, 5'd3, 1'b1, 1'b0, 8'h00);
        check("R11 tail blocked while busy", dma_req[2], 0);
        drive(5'd0, 5'd3, 1'b0, 1'b0, 8'h00);
        check("R11 tail when idle", dma_req[2], 1);
        check("R8 done on finish", status[7], 1);
        drive(5'd0, 5'd4, 1'b0, 1'b0, 8'h80);
        check("R11 no tail at rx == len", dma_req[2], 0);
        check("R6 done cleared", status[7], 0);

        // R6: zero write leaves sticky bits
        drive(5'd0, 5'd16, 1'b0, 1'b1, 8'h00);
        drive(5'd0, 5'd4, 1'b0, 1'b0, 8'h3F);
        check("R6 zero bit keeps overflow", status[6], 1);
        check("R7 level bits follow counts", status[5:0], 6'b001011);

        finish_run();
    end
endmodule